// File: doc/BRIEF.md
# Conditional Render Gate

The block decides whether later draw work may run. A command writes a render-gate mode together with the word address of a compare record. Two modes set the gate at once and read nothing. Three predicate modes first read a four-word record through a simple read port and then set the gate from a test on that record. The result is held in the registered `exec_en` output until the next mode is accepted.

Mode commands use a valid/ready handshake. `mode_ready` is low from the cycle after a predicate mode is accepted until its result is stored. A command offered during that time waits at the input and has no effect until it is accepted.

The read port has a request channel and a response channel:
- The request channel uses valid/ready. The block holds the request valid with a stable address until ready is seen.
- The response channel carries valid only. It has no back-pressure.
- Responses must return in the order the requests were made.

Top module: `cond_render_gate`

## Requirements
- R1: After reset, `exec_en` is 1, `busy` is 0, `mode_ready` is 1 and no read request is raised.
- R2: An accepted mode code 0 (force on) sets `exec_en` to 1 at the next clock edge and raises no read request.
- R3: An accepted mode code 1 (force off) sets `exec_en` to 0 at the next clock edge and raises no read request.
- R4: An accepted mode code 2, 3 or 4 raises `busy` at the next edge. It then issues exactly four read requests, at word addresses base, base+1, base+2 and base+3, in that order, with at most one per cycle. A request stalled by `rd_req_ready` low stays valid with the same address.
- R5: The four returned words are taken in request order as: word 0 initial sequence, word 1 initial tag, word 2 current sequence, word 3 current tag.
- R6: Mode code 2 gives `exec_en` = 1 only when both the initial sequence and the initial tag are nonzero.
- R7: Mode code 3 gives `exec_en` = 1 only when the initial sequence equals the current sequence and the initial tag equals the current tag.
- R8: Mode code 4 gives `exec_en` = 1 when the sequences differ or the tags differ.
- R9: Mode codes 5, 6 and 7 set `exec_en` to 1 at the next edge and raise no read request.
- R10: While `busy` is high, `exec_en` keeps its previous value. The new value appears at the clock edge that takes the fourth response, and `busy` falls at that same edge.
- R11: `mode_ready` is low while `busy` is high. A mode offered in that time is not taken and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_valid | input | 1 | Mode command offered |
| mode_ready | output | 1 | Mode command can be taken |
| mode_code | input | 3 | Mode code (0 on, 1 off, 2 both-set, 3 match, 4 differ, others on) |
| rec_addr | input | ADDR_W | Word address of the compare record |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by memory |
| rd_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| exec_en | output | 1 | Registered execute-enable flag |
| busy | output | 1 | Record fetch in progress |

## Verification
The fixed-mode results (codes 0, 1 and 5 to 7) are due one edge after acceptance. The bench samples them on the falling edge that follows the accepting rising edge.

Predicate results have no fixed delay, because they depend on how the memory stalls and answers. The bench notes the cycle in which it presents the fourth response and requires `busy` low and the new `exec_en` exactly one edge later. On every falling edge in between, it checks that `exec_en` is unchanged.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int WORD_W    = 32;
  localparam int REC_WORDS = 4;
  localparam int IDX_W     = $clog2(REC_WORDS);

  typedef logic [2:0] mode_t;
  localparam mode_t MODE_ON       = 3'd0;
  localparam mode_t MODE_OFF      = 3'd1;
  localparam mode_t MODE_BOTH_SET = 3'd2;
  localparam mode_t MODE_MATCH    = 3'd3;
  localparam mode_t MODE_DIFFER   = 3'd4;

  typedef struct packed {
    logic [WORD_W-1:0] init_seq;
    logic [WORD_W-1:0] init_tag;
    logic [WORD_W-1:0] cur_seq;
    logic [WORD_W-1:0] cur_tag;
  } record_t;

  function automatic logic mode_fetches(input mode_t m);
    return (m == MODE_BOTH_SET) || (m == MODE_MATCH) || (m == MODE_DIFFER);
  endfunction
endpackage

// File: rtl/cr_req_issuer.sv
module cr_req_issuer
  import cr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      req_addr <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      req_addr <= base;
    end else if (active_q && req_ready) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
      end else begin
        idx_q    <= idx_q + 1'b1;
        req_addr <= req_addr + 1'b1;
      end
    end
  end

  assign req_valid = active_q;
endmodule

// File: rtl/cr_rsp_collect.sv
module cr_rsp_collect
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              armed,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output record_t           rec,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

  logic [IDX_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q [REC_WORDS-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (armed && rsp_valid) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < REC_WORDS - 1; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (armed && rsp_valid && cnt_q == IDX_W'(g)) begin
        word_q[g] <= rsp_data;
      end
    end
  end

  assign done = armed && rsp_valid && (cnt_q == LAST_IDX);
  assign rec  = '{init_seq: word_q[0], init_tag: word_q[1],
                  cur_seq: word_q[2], cur_tag: rsp_data};
endmodule

// File: rtl/cr_judge.sv
module cr_judge
  import cr_pkg::*;
(
  input  mode_t   mode,
  input  record_t rec,
  output logic    pass
);
  logic seq_eq, tag_eq;

  assign seq_eq = (rec.init_seq == rec.cur_seq);
  assign tag_eq = (rec.init_tag == rec.cur_tag);

  always_comb begin
    case (mode)
      MODE_BOTH_SET: pass = (rec.init_seq != '0) && (rec.init_tag != '0);
      MODE_MATCH:    pass = seq_eq && tag_eq;
      MODE_DIFFER:   pass = !seq_eq || !tag_eq;
      default:       pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/cond_render_gate.sv
module cond_render_gate
  import cr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_valid,
  output logic              mode_ready,
  input  logic [2:0]        mode_code,
  input  logic [ADDR_W-1:0] rec_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              exec_en,
  output logic              busy
);
  logic    busy_q, exec_q;
  mode_t   mode_q;
  logic    accept, start_fetch;
  record_t rec;
  logic    rec_done, rec_pass;

  assign mode_ready  = !busy_q;
  assign accept      = mode_valid && mode_ready;
  assign start_fetch = accept && mode_fetches(mode_code);

  cr_req_issuer #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_fetch),
    .base      (rec_addr),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_addr)
  );

  cr_rsp_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_fetch),
    .armed     (busy_q),
    .rsp_valid (rd_rsp_valid),
    .rsp_data  (rd_rsp_data),
    .rec       (rec),
    .done      (rec_done)
  );

  cr_judge u_judge (
    .mode (mode_q),
    .rec  (rec),
    .pass (rec_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      exec_q <= 1'b1;
      mode_q <= MODE_ON;
    end else if (accept) begin
      mode_q <= mode_code;
      if (mode_fetches(mode_code)) begin
        busy_q <= 1'b1;
      end else begin
        exec_q <= (mode_code != MODE_OFF);
      end
    end else if (busy_q && rec_done) begin
      exec_q <= rec_pass;
      busy_q <= 1'b0;
    end
  end

  assign exec_en = exec_q;
  assign busy    = busy_q;
endmodule

// File: rtl/cr_gate_checker.sv
module cr_gate_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_valid,
  input logic              mode_ready,
  input logic [2:0]        mode_code,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rsp_valid,
  input logic              exec_en,
  input logic              busy
);
  logic taken;
  assign taken = mode_valid && mode_ready;

  a_r1_reset_on: assert property (@(posedge clk) $rose(rst_n) |-> exec_en && !busy);
  a_r2_force_on: assert property (@(posedge clk) disable iff (!rst_n)
    taken && mode_code == 3'd0 |=> exec_en && !busy);
  a_r3_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    taken && mode_code == 3'd1 |=> !exec_en && !busy);
  a_r9_unknown_on: assert property (@(posedge clk) disable iff (!rst_n)
    taken && mode_code >= 3'd5 |=> exec_en && !busy);
  a_r4_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    taken && mode_code >= 3'd2 && mode_code <= 3'd4 |=> busy);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));
  a_r4_req_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rd_rsp_valid |=> $stable(exec_en));
  a_r11_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mode_ready);
endmodule

bind cond_render_gate cr_gate_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_valid   (mode_valid),
  .mode_ready   (mode_ready),
  .mode_code    (mode_code),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_addr      (rd_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .exec_en      (exec_en),
  .busy         (busy)
);

// File: tb/cond_render_gate_bench.sv
`timescale 1ns/1ps
module cond_render_gate_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_valid = 1'b0;
  logic          mode_ready;
  logic [2:0]    mode_code = '0;
  logic [AW-1:0] rec_addr = '0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [31:0]   rd_rsp_data = '0;
  logic          exec_en, busy;

  always #2.5 clk = ~clk;

  cond_render_gate #(.ADDR_W(AW)) u_cond_render_gate (
    .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .mode_ready(mode_ready),
    .mode_code(mode_code), .rec_addr(rec_addr), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .exec_en(exec_en), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] mem [64];
  int pend [$];
  logic [AW-1:0] acc_log [$];
  int rsp_count = 0;
  int last_rsp_cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model(input logic [2:0] c, input logic [31:0] w0, input logic [31:0] w1,
                               input logic [31:0] w2, input logic [31:0] w3);
    case (c)
      3'd1: return 1'b0;
      3'd2: return (w0 != 0) && (w1 != 0);
      3'd3: return (w0 == w2) && (w1 == w3);
      3'd4: return (w0 != w2) || (w1 != w3);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial forever @(posedge clk) cyc++;

  // behavioural memory: in-order, random stalls and latency
  initial begin
    int ad;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
      end else begin
        if (pend.size() > 0 && ($urandom % 3) != 0) begin
          ad = pend.pop_front();
          rd_rsp_valid = 1'b1;
          rd_rsp_data = mem[ad];
          rsp_count++;
          last_rsp_cyc = cyc;
        end else begin
          rd_rsp_valid = 1'b0;
        end
        rd_req_ready = ($urandom % 4) != 0;
        if (rd_req_valid && rd_req_ready) begin
          pend.push_back(int'(rd_addr[5:0]));
          acc_log.push_back(rd_addr);
        end
      end
    end
  end

  task automatic run_mode(input logic [2:0] c, input int base, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3,
                          input bit intrude);
    bit exp, old;
    int t;
    mem[base] = w0; mem[base+1] = w1; mem[base+2] = w2; mem[base+3] = w3;
    exp = model(c, w0, w1, w2, w3);
    while (!mode_ready) @(negedge clk);
    acc_log.delete();
    rsp_count = 0;
    old = exec_en;
    mode_code = c;
    rec_addr = AW'(base);
    mode_valid = 1'b1;
    @(negedge clk);
    mode_valid = 1'b0;
    if (c >= 3'd2 && c <= 3'd4) begin
      chk(busy == 1'b1, "R4 busy after fetch mode", busy, 1);
      if (intrude) begin
        mode_code = 3'd1;
        mode_valid = 1'b1;
      end
      t = 0;
      while (busy && t < 2000) begin
        chk(exec_en == old, "R10 hold while busy", exec_en, old);
        if (intrude) chk(mode_ready == 1'b0, "R11 ready low while busy", mode_ready, 0);
        @(negedge clk);
        t++;
      end
      mode_valid = 1'b0;
      chk(t < 2000, "R4 fetch completes", t, 0);
      chk(cyc == last_rsp_cyc + 1, "R10 update one edge after last word", cyc, last_rsp_cyc + 1);
      chk(rsp_count == 4, "R5 four words returned", rsp_count, 4);
      chk(acc_log.size() == 4, "R4 four requests", acc_log.size(), 4);
      for (int i = 0; i < 4 && i < acc_log.size(); i++)
        chk(acc_log[i] == AW'(base + i), "R4 request address order", acc_log[i], base + i);
      chk(exec_en == exp, tag_of(c), exec_en, exp);
      if (intrude) begin
        @(negedge clk);
        chk(exec_en == exp && !busy, "R11 held-off mode had no effect", exec_en, exp);
      end
    end else begin
      chk(exec_en == exp, tag_of(c), exec_en, exp);
      chk(busy == 1'b0, "R2 R3 R9 no busy", busy, 0);
      repeat (2) @(negedge clk);
      chk(acc_log.size() == 0, "R2 R3 R9 no read request", acc_log.size(), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b, cc, d;
    int base, sel;
    logic [2:0] c;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(exec_en == 1'b1, "R1 reset exec_en", exec_en, 1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(mode_ready == 1'b1, "R1 reset ready", mode_ready, 1);
    chk(rd_req_valid == 1'b0, "R1 reset no request", rd_req_valid, 0);

    run_mode(3'd1, 0, 0, 0, 0, 0, 0);
    run_mode(3'd0, 0, 0, 0, 0, 0, 0);
    run_mode(3'd1, 0, 0, 0, 0, 0, 0);
    run_mode(3'd5, 0, 0, 0, 0, 0, 0);
    run_mode(3'd1, 0, 0, 0, 0, 0, 0);
    run_mode(3'd7, 0, 0, 0, 0, 0, 0);
    run_mode(3'd2, 4, 32'h0, 32'h5, 32'h1, 32'h1, 0);
    run_mode(3'd2, 8, 32'h9, 32'h0, 32'h1, 32'h1, 0);
    run_mode(3'd2, 12, 32'h9, 32'h3, 32'h0, 32'h0, 0);
    run_mode(3'd3, 16, 32'hA, 32'hB, 32'hA, 32'hB, 0);
    run_mode(3'd3, 20, 32'hA, 32'hB, 32'hC, 32'hB, 0);
    run_mode(3'd3, 24, 32'hA, 32'hB, 32'hA, 32'hD, 0);
    run_mode(3'd4, 28, 32'h7, 32'h8, 32'h7, 32'h8, 0);
    run_mode(3'd4, 32, 32'h7, 32'h8, 32'h7, 32'h9, 0);
    run_mode(3'd4, 36, 32'h7, 32'h8, 32'h6, 32'h8, 0);
    run_mode(3'd3, 60, 32'h1, 32'h2, 32'h1, 32'h2, 1);
    run_mode(3'd2, 40, 32'h0, 32'h2, 32'h1, 32'h2, 1);

    for (int n = 0; n < 80; n++) begin
      c = 3'($urandom % 8);
      base = $urandom % 61;
      a = $urandom; b = $urandom; cc = $urandom; d = $urandom;
      sel = $urandom % 4;
      if (sel == 0) begin cc = a; d = b; end
      else if (sel == 1) begin cc = a; end
      else if (sel == 2) begin a = 0; end
      run_mode(c, base, a, b, cc, d, ($urandom % 5) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule